// File: doc/BRIEF.md
# Text-Mode Character Row Renderer

This block produces a serial monochrome pixel stream for a character-cell text display. Free-running raster counters step through the pixel within a cell, the character column, the scanline within a character row, and the character row. At each character position a character code is read from a 256-byte video RAM at the current row's base address plus the column. The code and the scanline number then select one 8-pixel slice from a 4 KB glyph ROM. The slice is loaded into a shift register and sent out one pixel per clock, leftmost pixel first.

A cursor is given as a column and a row. At the matching cell the whole slice is inverted on every scanline of that cell. Outside the visible window the pixel output is held low and an active-low blank flag is driven. The video RAM and the glyph ROM are synchronous arrays inside the block, and each has a plain write port so that they can be filled. Memory reads run one character time ahead of the shifter, so consecutive cells leave no gap between them.

Top module: `text_row_render`

## Requirements
- R1: While `rst_n` is low, `pix_out` and `blank_n` are 0. In the first 8 clocks after reset is released they stay 0.
- R2: One character time is 8 clocks. A scanline is `H_TOTAL` character times, a character row is `LINES` scanlines, and a frame is `V_TOTAL` character rows. `blank_n` is 1 exactly for cells whose column is below `H_VIS` and whose row is below `V_VIS`. `pix_out` is 0 whenever `blank_n` is 0.
- R3: Counting clock edges after reset release from 0, character time k (k = 0, 1, 2, ...) is output during edges 8(k+1) to 8(k+1)+7, with glyph bit 7 first and bit 0 last. `blank_n` changes only on a character boundary.
- R4: The video RAM address for a cell is (row base + column) modulo 256.
- R5: The row base is 0 in the first frame after reset. It increases by `H_VIS` (modulo 256) at the end of each character row. At the end of the last row of a frame it is reloaded from `start_addr`.
- R6: The glyph ROM address is {scanline[LINE_BITS-1:0], code[7:0]}, so the scanline selects a 256-byte plane.
- R7: The cursor inputs are registered. A cell whose column equals `cursor_col` and whose row equals `cursor_row` has its 8-bit slice XORed with 0xFF before it is shifted out.
- R8: A cursor placed in a blanked column or row has no visible effect. Blanking takes priority and no other cell changes.
- R9: A write with `ram_we` or `rom_we` high stores the data at the given address on the rising clock edge, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_we | input | 1 | Video RAM write enable |
| ram_waddr | input | VRAM_AW | Video RAM write address |
| ram_wdata | input | 8 | Video RAM write data (character code) |
| rom_we | input | 1 | Glyph ROM write enable |
| rom_waddr | input | LINE_BITS+8 | Glyph ROM write address {scanline, code} |
| rom_wdata | input | 8 | Glyph slice, bit 7 leftmost |
| start_addr | input | VRAM_AW | Row base loaded at the top of each frame |
| cursor_col | input | COL_W | Cursor column |
| cursor_row | input | ROW_W | Cursor character row |
| pix_out | output | 1 | Serial pixel |
| blank_n | output | 1 | Low outside the visible window |

## Verification
The bench fills both memories with computed patterns and compares every output pixel and blank bit over two full frames against a model built from the requirements.

The scenarios target specific failure modes:
- A start address of 250 makes the video RAM address wrap past 255. A design that carries into a ninth bit would read the wrong codes after the wrap.
- Every scenario covers two frames. A renderer that ignored `start_addr` would show the wrong text in the second frame, and one that loaded it at the wrong time would show it in the first.
- The cursor is placed at the last visible column and row, in a blanked column, and in a blanked row. A design that inverted the wrong cell, or let the inversion leak past blanking, would produce wrong pixels.
- The one-character pipeline offset and the left-to-right bit order are checked at every pixel. An off-by-one fetch or a reversed shifter fails on the first visible cell.

// File: rtl/text_row_render.sv
module text_row_render #(
  parameter int H_TOTAL   = 53,
  parameter int H_VIS     = 40,
  parameter int V_TOTAL   = 32,
  parameter int V_VIS     = 25,
  parameter int LINES     = 8,
  parameter int LINE_BITS = 4,
  parameter int VRAM_AW   = 8,
  parameter int COL_W     = $clog2(H_TOTAL),
  parameter int ROW_W     = $clog2(V_TOTAL)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ram_we,
  input  logic [VRAM_AW-1:0]     ram_waddr,
  input  logic [7:0]             ram_wdata,
  input  logic                   rom_we,
  input  logic [LINE_BITS+7:0]   rom_waddr,
  input  logic [7:0]             rom_wdata,
  input  logic [VRAM_AW-1:0]     start_addr,
  input  logic [COL_W-1:0]       cursor_col,
  input  logic [ROW_W-1:0]       cursor_row,
  output logic                   pix_out,
  output logic                   blank_n
);
  localparam int GROM_AW = LINE_BITS + 8;

  logic [2:0]           pix_cnt;
  logic [COL_W-1:0]     col_cnt;
  logic [LINE_BITS-1:0] line_cnt;
  logic [ROW_W-1:0]     row_cnt;
  logic [VRAM_AW-1:0]   row_base;
  logic [COL_W-1:0]     cur_col_q;
  logic [ROW_W-1:0]     cur_row_q;
  logic [7:0]           ram_q, rom_q, shreg;
  logic                 vis_q;

  logic [7:0] vram [2**VRAM_AW];
  logic [7:0] grom [2**GROM_AW];

  logic char_end, col_end, line_end, row_end, vis, on_cursor;
  assign char_end  = (pix_cnt == 3'd7);
  assign col_end   = (int'(col_cnt) == H_TOTAL - 1);
  assign line_end  = (int'(line_cnt) == LINES - 1);
  assign row_end   = (int'(row_cnt) == V_TOTAL - 1);
  assign vis       = (int'(col_cnt) < H_VIS) && (int'(row_cnt) < V_VIS);
  assign on_cursor = (col_cnt == cur_col_q) && (row_cnt == cur_row_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_cnt  <= '0;
      col_cnt  <= '0;
      line_cnt <= '0;
      row_cnt  <= '0;
      row_base <= '0;
    end else begin
      pix_cnt <= pix_cnt + 3'd1;
      if (char_end) begin
        col_cnt <= col_end ? '0 : col_cnt + COL_W'(1);
        if (col_end) begin
          line_cnt <= line_end ? '0 : line_cnt + LINE_BITS'(1);
          if (line_end) begin
            row_cnt  <= row_end ? '0 : row_cnt + ROW_W'(1);
            row_base <= row_end ? start_addr : row_base + VRAM_AW'(H_VIS);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_col_q <= '0;
      cur_row_q <= '0;
    end else begin
      cur_col_q <= cursor_col;
      cur_row_q <= cursor_row;
    end
  end

  always_ff @(posedge clk) begin
    if (ram_we) vram[ram_waddr] <= ram_wdata;
    ram_q <= vram[row_base + VRAM_AW'(col_cnt)];
  end

  always_ff @(posedge clk) begin
    if (rom_we) grom[rom_waddr] <= rom_wdata;
    rom_q <= grom[{line_cnt, ram_q}];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      vis_q <= 1'b0;
    end else if (char_end) begin
      shreg <= rom_q ^ {8{on_cursor}};
      vis_q <= vis;
    end else begin
      shreg <= {shreg[6:0], 1'b0};
    end
  end

  assign pix_out = vis_q & shreg[7];
  assign blank_n = vis_q;
endmodule

// File: rtl/text_row_render_chk.sv
module text_row_render_chk #(
  parameter int H_TOTAL   = 53,
  parameter int H_VIS     = 40,
  parameter int V_TOTAL   = 32,
  parameter int LINES     = 8,
  parameter int LINE_BITS = 4,
  parameter int VRAM_AW   = 8,
  parameter int COL_W     = 6,
  parameter int ROW_W     = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pix_out,
  input logic                 blank_n,
  input logic [2:0]           pix_cnt,
  input logic [COL_W-1:0]     col_cnt,
  input logic [LINE_BITS-1:0] line_cnt,
  input logic [ROW_W-1:0]     row_cnt,
  input logic [VRAM_AW-1:0]   row_base,
  input logic [VRAM_AW-1:0]   start_addr
);
  logic row_done;
  assign row_done = (pix_cnt == 3'd7) && (int'(col_cnt) == H_TOTAL - 1) &&
                    (int'(line_cnt) == LINES - 1);

  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> !pix_out); // R2
  AST_RASTER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(col_cnt) < H_TOTAL) && (int'(row_cnt) < V_TOTAL) && (int'(line_cnt) < LINES)); // R2
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_cnt == 3'd7 && int'(col_cnt) != H_TOTAL - 1) |=> col_cnt == $past(col_cnt) + COL_W'(1)); // R2
  AST_BASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (row_done && int'(row_cnt) != V_TOTAL - 1) |=> row_base == $past(row_base) + VRAM_AW'(H_VIS)); // R5
  AST_BASE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (row_done && int'(row_cnt) == V_TOTAL - 1) |=> row_base == $past(start_addr)); // R5
  AST_CHAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_cnt != 3'd0) |-> $stable(blank_n)); // R3
endmodule

bind text_row_render text_row_render_chk #(
  .H_TOTAL(H_TOTAL), .H_VIS(H_VIS), .V_TOTAL(V_TOTAL), .LINES(LINES),
  .LINE_BITS(LINE_BITS), .VRAM_AW(VRAM_AW), .COL_W(COL_W), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_out(pix_out), .blank_n(blank_n),
  .pix_cnt(pix_cnt), .col_cnt(col_cnt), .line_cnt(line_cnt),
  .row_cnt(row_cnt), .row_base(row_base), .start_addr(start_addr)
);

// File: tb/text_row_render_bench.sv
module text_row_render_bench;
  localparam int HT = 9, HV = 6, VT = 5, VV = 3, LN = 8;
  localparam int FRAME_CYC = HT * 8 * LN * VT;
  localparam int COLW = $clog2(HT), ROWW = $clog2(VT);

  // {start_addr, cursor_col, cursor_row}
  localparam logic [23:0] SCEN [5] = '{
    {8'd0,   8'd2, 8'd1},   // plain cursor inside window (R7)
    {8'd250, 8'd0, 8'd0},   // VRAM wrap past 255 (R4, R5)
    {8'd17,  8'd5, 8'd2},   // last visible column and row (R7)
    {8'd100, 8'd2, 8'd4},   // cursor in blanked row (R8)
    {8'd3,   8'd7, 8'd1}    // cursor in blanked column (R8)
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ram_we = 1'b0, rom_we = 1'b0;
  logic [7:0] ram_waddr = '0, ram_wdata = '0, rom_wdata = '0;
  logic [11:0] rom_waddr = '0;
  logic [7:0] start_addr = '0;
  logic [COLW-1:0] cursor_col = '0;
  logic [ROWW-1:0] cursor_row = '0;
  logic pix_out, blank_n;

  int errors = 0, checks = 0;
  logic [7:0] ram_m [256];

  always #10 clk = ~clk;

  text_row_render #(.H_TOTAL(HT), .H_VIS(HV), .V_TOTAL(VT), .V_VIS(VV), .LINES(LN))
    u_text_row_render (
    .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_waddr(ram_waddr),
    .ram_wdata(ram_wdata), .rom_we(rom_we), .rom_waddr(rom_waddr),
    .rom_wdata(rom_wdata), .start_addr(start_addr), .cursor_col(cursor_col),
    .cursor_row(cursor_row), .pix_out(pix_out), .blank_n(blank_n));

  function automatic logic [7:0] romf(int a);
    return 8'(a * 37 + (a >> 8) * 11 + 5);
  endfunction

  task automatic chk(logic got, logic exp, string req, int n);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s edge=%0d actual=%b expected=%b", req, n, got, exp);
    end
  endtask

  task automatic model(int nn, int st, int cc, int cr, output logic ep, output logic eb);
    int k, b, col, r, line, ra, fr, row, base;
    logic [7:0] g;
    if (nn < 8) begin ep = 1'b0; eb = 1'b0; return; end
    k = nn / 8 - 1; b = 7 - nn % 8;
    col = k % HT; r = k / HT; line = r % LN; ra = r / LN;
    fr = ra / VT; row = ra % VT;
    eb = (col < HV) && (row < VV);
    base = ((fr == 0 ? 0 : st) + row * HV) % 256;
    g = romf(line * 256 + int'(ram_m[(base + col) % 256]));
    if (col == cc && row == cr) g = ~g;
    ep = eb & g[b];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ep, eb;
    for (int a = 0; a < 4096; a++) begin   // R9 glyph load, R6 plane layout
      @(negedge clk);
      rom_we = 1'b1; rom_waddr = 12'(a); rom_wdata = romf(a);
    end
    @(negedge clk); rom_we = 1'b0;

    for (int s = 0; s < 5; s++) begin
      rst_n = 1'b0;
      for (int a = 0; a < 256; a++) begin  // R9 video RAM load
        @(negedge clk);
        ram_we = 1'b1; ram_waddr = 8'(a); ram_wdata = 8'(a * 13 + s * 29 + 7);
        ram_m[a] = 8'(a * 13 + s * 29 + 7);
      end
      @(negedge clk);
      ram_we = 1'b0;
      start_addr = SCEN[s][23:16];
      cursor_col = COLW'(SCEN[s][15:8]);
      cursor_row = ROWW'(SCEN[s][7:0]);
      @(negedge clk);
      chk(pix_out, 1'b0, "R1 pix in reset", 0);
      chk(blank_n, 1'b0, "R1 blank in reset", 0);
      rst_n = 1'b1;
      for (int n = 1; n <= 2 * FRAME_CYC + 16; n++) begin
        @(posedge clk); @(negedge clk);
        model(n, int'(SCEN[s][23:16]), int'(SCEN[s][15:8]), int'(SCEN[s][7:0]), ep, eb);
        chk(pix_out, ep, "R3 R4 R5 R6 R7 R8 pixel", n);
        chk(blank_n, eb, "R1 R2 blank", n);
      end
    end

    #3 rst_n = 1'b0;   // asynchronous reset mid-run
    #1;
    chk(pix_out, 1'b0, "R1 async pix", -1);
    chk(blank_n, 1'b0, "R1 async blank", -1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule